// File: doc/BRIEF.md
# Programmable Key Input Chattering Filter

This block removes contact bounce from an 8-bit key input port. The port is split into a low nibble (bits 3..0) and a high nibble (bits 7..4). Each nibble has its own 3-bit filter-time code. A nonzero code makes a level change wait for confirmation before it reaches the filtered port. A zero code lets the synchronized input through unchanged.

Each nibble has one free-running counter. The counter raises a sample tick once per verification period. A bit's filtered level moves to a new value only when two consecutive ticks see that same new value. A change is therefore accepted between one and two periods after it settles, and a glitch no longer than one period is dropped.

Every filtered bit feeds an edge detector. The detector gives a one-clock interrupt request on the edge direction chosen by that bit's polarity input. The raw pins pass through a two-flop synchronizer before anything else.

Top module: `keydb_top`

## Requirements
- R1: The low nibble (bits 3..0) is governed only by `sel_lo`, and the high nibble (bits 7..4) only by `sel_hi`. A nibble in bypass follows its input while the other nibble is still filtering.
- R2: With code 0, a change on `key_in` shows on `key_out` after exactly three rising clock edges (two synchronizer stages and the filter register), and not earlier.
- R3: A nonzero code c gives a verification period T = 2^(BASE_SHIFT+c) clock cycles. With the default BASE_SHIFT = 7 this is 256 to 16384 cycles. An input level held steady is accepted between T+3 and 2T+2 clock edges after the raw change.
- R4: In filtering mode, a filtered bit changes only on its nibble's sample tick. Two bits of one nibble that are accepted at different times change a whole number of periods T apart.
- R5: A pulse on a filtered input that lasts T-1 cycles never reaches `key_out` and raises no interrupt.
- R6: A level held for 2T cycles or longer is always accepted onto `key_out`.
- R7: During reset, `key_out` loads the synchronized input, and no interrupt fires in the first cycle after reset.
- R8: `key_irq[i]` is high for exactly one cycle, in the same cycle that `key_out[i]` takes the edge selected by `edge_pol[i]`. A value of 1 selects the rising edge (0 to 1) and a value of 0 selects the falling edge (1 to 0).
- R9: An edge of `key_out[i]` in the direction opposite to `edge_pol[i]` raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; all periods are counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| key_in | input | 8 | Raw key pins, asynchronous to clk |
| sel_lo | input | 3 | Filter-time code for bits 3..0; 0 selects bypass |
| sel_hi | input | 3 | Filter-time code for bits 7..4; 0 selects bypass |
| edge_pol | input | 8 | Per-bit interrupt edge: 1 selects rising, 0 selects falling |
| key_out | output | 8 | Filtered key levels |
| key_irq | output | 8 | One-cycle interrupt request for each bit |

## Verification
The bench builds the block with BASE_SHIFT = 2. This shrinks the periods to between 8 and 512 cycles, so all seven nonzero codes can be run through rejection, acceptance and latency-window checks within a few thousand cycles. The exact bounds T+3 and 2T+2 are measured per bit, because every period stays a power of two exactly as at the default. The tick-phase alignment between bits, the bypass latency and the mixed-mode nibbles are also covered at this setting.

// File: rtl/keydb_pkg.sv
package keydb_pkg;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned CODE_MAX = (1 << SEL_W) - 1;

  // exponent of the verification period for a nonzero code
  function automatic int unsigned period_exp(input int unsigned base_shift,
                                             input logic [SEL_W-1:0] code);
    return base_shift + int'(code);
  endfunction

  // low-bit mask whose all-ones state marks the last cycle of a period
  function automatic logic [31:0] period_mask(input int unsigned base_shift,
                                              input logic [SEL_W-1:0] code);
    return (32'd1 << period_exp(base_shift, code)) - 32'd1;
  endfunction
endpackage

// File: rtl/keydb_sync.sv
module keydb_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  // two stages; no reset so the chain keeps sampling during reset
  always_ff @(posedge clk) begin
    meta_q <= d;
    q      <= meta_q;
  end
endmodule

// File: rtl/keydb_group.sv
module keydb_group
  import keydb_pkg::*;
#(
  parameter int unsigned GW         = 4,
  parameter int unsigned BASE_SHIFT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] code,
  input  logic [GW-1:0]    samp,
  output logic [GW-1:0]    filt
);
  localparam int unsigned CW = BASE_SHIFT + CODE_MAX;

  logic [CW-1:0]  cnt_q;
  logic [31:0]    mask_w;
  logic [31:0]    cnt_ext;
  logic           bypass;
  logic           tick;
  logic [GW-1:0]  cand_q;

  assign bypass  = (code == '0);
  assign mask_w  = period_mask(BASE_SHIFT, code);
  assign cnt_ext = {{(32-CW){1'b0}}, cnt_q};
  assign tick    = !bypass && ((cnt_ext & mask_w) == mask_w);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < GW; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n || bypass) begin
        filt[i]   <= samp[i];
        cand_q[i] <= samp[i];
      end else if (tick) begin
        cand_q[i] <= samp[i];
        if (samp[i] == cand_q[i]) filt[i] <= samp[i];
      end
    end

    // R4
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(code) != '0 && filt[i] != $past(filt[i])) |-> $past(tick));

    // R5
    two_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(code) != '0 && filt[i] != $past(filt[i]))
        |-> (filt[i] == $past(cand_q[i])));
  end

  // R2
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(code) == '0) |-> (filt == $past(samp)));
endmodule

// File: rtl/keydb_edge.sv
module keydb_edge #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] filt,
  input  logic [W-1:0] pol,
  output logic [W-1:0] irq
);
  logic [W-1:0] prev_q;

  // reset loads the same value the filter loads, so no edge appears
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= ld_val;
    else        prev_q <= filt;
  end

  assign irq = (filt ^ prev_q) & ~(filt ^ pol);

  // R7
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == '0));

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(irq[i]) && $stable(pol[i])) |-> !irq[i]);
  end
endmodule

// File: rtl/keydb_top.sv
module keydb_top
  import keydb_pkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned BASE_SHIFT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] key_in,
  input  logic [SEL_W-1:0] sel_lo,
  input  logic [SEL_W-1:0] sel_hi,
  input  logic [WIDTH-1:0] edge_pol,
  output logic [WIDTH-1:0] key_out,
  output logic [WIDTH-1:0] key_irq
);
  localparam int unsigned NGROUPS = 2;
  localparam int unsigned GW      = WIDTH / NGROUPS;

  logic [WIDTH-1:0] sync_q;
  logic [SEL_W-1:0] sel_arr [NGROUPS];

  assign sel_arr[0] = sel_lo;
  assign sel_arr[1] = sel_hi;

  keydb_sync #(.W(WIDTH)) u_sync (
    .clk (clk),
    .d   (key_in),
    .q   (sync_q)
  );

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    keydb_group #(.GW(GW), .BASE_SHIFT(BASE_SHIFT)) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (sel_arr[g]),
      .samp  (sync_q[g*GW +: GW]),
      .filt  (key_out[g*GW +: GW])
    );
  end

  keydb_edge #(.W(WIDTH)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_val (sync_q),
    .filt   (key_out),
    .pol    (edge_pol),
    .irq    (key_irq)
  );
endmodule

// File: tb/test_keydb_top.sv
module test_keydb_top;
  localparam int BS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] key_in = 8'h00;
  logic [2:0] sel_lo = 3'd0;
  logic [2:0] sel_hi = 3'd0;
  logic [7:0] edge_pol = 8'hFF;
  logic [7:0] key_out;
  logic [7:0] key_irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int irq_cnt [8];
  int chg_cyc [8];
  logic [7:0] last_out = 8'h00;

  always #10 clk = ~clk;

  keydb_top #(.WIDTH(8), .BASE_SHIFT(BS)) i_keydb_top (
    .clk(clk), .rst_n(rst_n), .key_in(key_in), .sel_lo(sel_lo), .sel_hi(sel_hi),
    .edge_pol(edge_pol), .key_out(key_out), .key_irq(key_irq)
  );

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    #2;
    if (rst_n) begin
      for (int i = 0; i < 8; i++) begin
        irq_cnt[i] = irq_cnt[i] + int'(key_irq[i]);
        if (key_out[i] != last_out[i]) chg_cyc[i] = cyc;
      end
    end
    last_out = key_out;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_irq();
    for (int i = 0; i < 8; i++) irq_cnt[i] = 0;
  endtask

  function automatic int irq_total();
    int s = 0;
    for (int i = 0; i < 8; i++) s += irq_cnt[i];
    return s;
  endfunction

  // period restated from R3
  function automatic int per(input int code);
    return 1 << (BS + code);
  endfunction

  // R7: reset load and a quiet first cycle
  task automatic t_reset();
    key_in = 8'hA5;
    wait_cyc(5);
    rst_n = 1'b1;
    clr_irq();
    wait_cyc(5);
    chk(key_out == 8'hA5, "R7", "key_out after reset", key_out, 8'hA5);
    chk(irq_total() == 0, "R7", "irq after reset", irq_total(), 0);
  endtask

  // R2 latency, R8 rising pulses, R9 falling ignored
  task automatic t_bypass();
    sel_lo = 3'd0; sel_hi = 3'd0; edge_pol = 8'hFF;
    wait_cyc(2); clr_irq();
    key_in = 8'h5A;
    wait_cyc(2);
    chk(key_out == 8'hA5, "R2", "bypass not early", key_out, 8'hA5);
    wait_cyc(1);
    chk(key_out == 8'h5A, "R2", "bypass at 3 edges", key_out, 8'h5A);
    wait_cyc(2);
    for (int i = 0; i < 8; i++) begin
      if (i == 1 || i == 3 || i == 4 || i == 6)
        chk(irq_cnt[i] == 1, "R8", "rising irq count", irq_cnt[i], 1);
      else
        chk(irq_cnt[i] == 0, "R9", "falling irq ignored", irq_cnt[i], 0);
    end
    edge_pol = 8'h00; clr_irq();
    key_in = 8'h00;
    wait_cyc(5);
    chk(irq_cnt[1] == 1 && irq_cnt[0] == 0, "R8", "falling polarity bit1",
        irq_cnt[1], 1);
    edge_pol = 8'hFF;
  endtask

  // R3, R5, R6, R8, R9 for one nonzero code on both nibbles
  task automatic t_filter(input int code);
    int t;
    int s0;
    int lat;
    t = per(code);
    // interrupts are disregarded while the code changes
    sel_lo = 3'(code); sel_hi = 3'(code);
    wait_cyc(4); clr_irq();
    key_in = 8'h11;
    wait_cyc(t - 1);
    key_in = 8'h00;
    wait_cyc(3 * t);
    chk(key_out == 8'h00, "R5", $sformatf("short pulse code %0d", code), key_out, 0);
    chk(irq_total() == 0, "R5", $sformatf("no irq code %0d", code), irq_total(), 0);
    s0 = cyc;
    key_in = 8'h11;
    wait_cyc(2 * t + 4);
    chk(key_out == 8'h11, "R6", $sformatf("held level code %0d", code), key_out, 8'h11);
    for (int b = 0; b < 8; b += 4) begin
      lat = chg_cyc[b] - s0;
      chk(lat >= t + 3 && lat <= 2 * t + 2, "R3",
          $sformatf("latency bit %0d code %0d", b, code), lat, t + 3);
    end
    chk(irq_cnt[0] == 1 && irq_cnt[4] == 1, "R8", "one rising irq",
        irq_cnt[0] + irq_cnt[4], 2);
    key_in = 8'h00;
    wait_cyc(2 * t + 4);
    chk(key_out == 8'h00, "R6", "held low accepted", key_out, 0);
    chk(irq_cnt[0] == 1 && irq_cnt[4] == 1, "R9", "falling ignored",
        irq_cnt[0] + irq_cnt[4], 2);
  endtask

  // R4: two bits accepted a whole number of periods apart
  task automatic t_phase();
    int t;
    int d;
    t = per(3);
    sel_lo = 3'd3; key_in = 8'h00;
    wait_cyc(4);
    key_in = 8'h01;
    wait_cyc(t / 2 + 1);
    key_in = 8'h03;
    wait_cyc(2 * t + 4);
    d = chg_cyc[1] - chg_cyc[0];
    chk(key_out[1:0] == 2'b11, "R4", "both bits accepted", key_out[1:0], 3);
    chk(d % t == 0, "R4", "tick alignment", d % t, 0);
    key_in = 8'h00;
    wait_cyc(2 * t + 4);
  endtask

  // R1: bypassed high nibble, slow low nibble
  task automatic t_indep();
    int t;
    t = per(7);
    sel_lo = 3'd7; sel_hi = 3'd0;
    wait_cyc(4);
    key_in = 8'hFF;
    wait_cyc(4);
    chk(key_out == 8'hF0, "R1", "high bypass, low held", key_out, 8'hF0);
    wait_cyc(2 * t + 2);
    chk(key_out == 8'hFF, "R1", "low nibble accepted", key_out, 8'hFF);
    sel_hi = 3'd7; sel_lo = 3'd0;
    wait_cyc(4);
    key_in = 8'h00;
    wait_cyc(4);
    chk(key_out == 8'hF0, "R1", "low bypass, high held", key_out, 8'hF0);
    wait_cyc(2 * t + 2);
    sel_hi = 3'd0;
    wait_cyc(4);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin irq_cnt[i] = 0; chg_cyc[i] = 0; end
    t_reset();
    t_bypass();
    for (int c = 1; c <= 7; c++) t_filter(c);
    sel_lo = 3'd0; sel_hi = 3'd0;
    wait_cyc(4);
    t_phase();
    t_indep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule